// File: doc/BRIEF.md
# Branch Confidence Estimator

This block keeps a table of small signed counters, one per slot, that rate how much the current direction guess for a branch can be trusted. The front end asks about a fetch address and receives one bit: set when the slot for that address is above zero, so fetch may run on past the branch. When the bit is clear, fetch may hold back and save the energy a wrong path would waste. The stall decision and the direction predictor live elsewhere.

When a branch resolves, the back end reports its address and whether the guess was right. A right guess raises the slot by one and a wrong guess lowers it by nine. A slot therefore drifts upward only while about nine guesses in ten or more are right. Counters clamp at both ends of their signed range instead of wrapping. Slots carry no tags, so branches that share the selected address bits share a counter.

Top module: `branch_conf_est`

## Requirements
- R1: After reset every slot holds zero, so every query address reports not confident.
- R2: An update with `upd_valid`=1 and `upd_hit`=1 adds 1 to the slot selected by `upd_pc`; the counter (6-bit signed by default, range -32..31) stays at 31 once there.
- R3: An update with `upd_valid`=1 and `upd_hit`=0 subtracts 9 from the selected slot; the result is clamped at -32 instead of wrapping.
- R4: `qry_conf` is 1 exactly when the slot selected by `qry_pc` is strictly greater than zero, shown in the same cycle as `qry_pc` (default, unregistered output).
- R5: The slot is chosen by address bits [9:2] only (256 slots); addresses that differ only in bits [1:0] or in bits above 9 select the same slot.
- R6: When a query and an update hit the same slot in one cycle, `qry_conf` reflects the slot value from before that update; the new value shows from the next cycle.
- R7: While `upd_valid`=0, `upd_pc` and `upd_hit` change no slot.
- R8: An update changes only the slot its address selects; other slots keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| qry_pc | input | 32 | Fetch address being asked about |
| qry_conf | output | 1 | 1 when the selected slot is above zero |
| upd_valid | input | 1 | Resolved-branch report present this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_hit | input | 1 | 1 when the direction guess was right, 0 when wrong |

## Verification
A query and an update can land on the same slot in one cycle. The bench raises one slot to +1. It then presents a wrong-guess update and a query on that slot together, and expects the confident bit still set during that cycle and clear in the cycle after the edge. A design that forwarded the new value, or one that lost the write, gives a different pair of results.

// File: rtl/bce_pkg.sv
package bce_pkg;

   typedef enum logic {
      IDX_PLAIN = 1'b0,
      IDX_FOLD  = 1'b1
   } idx_mode_e;

   function automatic int clamp_int(input int v, input int lo, input int hi);
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

endpackage

// File: rtl/bce_index.sv
module bce_index
   import bce_pkg::*;
#(
   parameter int        PC_W   = 32,
   parameter int        IDX_LO = 2,
   parameter int        IDX_W  = 8,
   parameter idx_mode_e MODE   = IDX_PLAIN
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx
);

   localparam int SPAN = (MODE == IDX_FOLD) ? 2 * IDX_W : IDX_W;

   generate
      if (IDX_LO + SPAN > PC_W) begin : g_bad_span
         $error("bce_index: index bits exceed address width");
      end
      if (MODE == IDX_FOLD) begin : g_fold
         assign idx = pc[IDX_LO +: IDX_W] ^ pc[IDX_LO + IDX_W +: IDX_W];
      end else begin : g_plain
         assign idx = pc[IDX_LO +: IDX_W];
      end
   endgenerate

endmodule

// File: rtl/bce_step.sv
module bce_step
   import bce_pkg::*;
#(
   parameter int CNT_W = 6,
   parameter int INC   = 1,
   parameter int DEC   = 9
) (
   input  logic signed [CNT_W-1:0] cur,
   input  logic                    hit,
   output logic signed [CNT_W-1:0] nxt
);

   localparam int CMAX = (1 << (CNT_W - 1)) - 1;
   localparam int CMIN = -(1 << (CNT_W - 1));

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("bce_step: counter width out of range");
      end
      if (INC < 1 || DEC < 1) begin : g_bad_step
         $error("bce_step: step sizes must be positive");
      end
      if (DEC > CMAX - CMIN) begin : g_bad_dec
         $error("bce_step: penalty larger than counter range");
      end
   endgenerate

   always_comb begin
      int v;
      v = int'(cur);
      if (hit) v = v + INC;
      else     v = v - DEC;
      v   = clamp_int(v, CMIN, CMAX);
      nxt = CNT_W'(v);
   end

endmodule

// File: rtl/bce_table.sv
module bce_table #(
   parameter int IDX_W = 8,
   parameter int CNT_W = 6,
   parameter int INC   = 1,
   parameter int DEC   = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [IDX_W-1:0]        rd_idx,
   output logic signed [CNT_W-1:0] rd_val,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic                    wr_hit
);

   localparam int DEPTH = 1 << IDX_W;
   localparam int CMAX  = (1 << (CNT_W - 1)) - 1;
   localparam int CMIN  = -(1 << (CNT_W - 1));

   generate
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_depth
         $error("bce_table: index width out of range");
      end
   endgenerate

   logic signed [CNT_W-1:0] mem [DEPTH];
   logic signed [CNT_W-1:0] wr_cur;
   logic signed [CNT_W-1:0] wr_nxt;

   assign wr_cur = mem[wr_idx];
   assign rd_val = mem[rd_idx];

   bce_step #(
      .CNT_W (CNT_W),
      .INC   (INC),
      .DEC   (DEC)
   ) u_step (
      .cur (wr_cur),
      .hit (wr_hit),
      .nxt (wr_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_idx] <= wr_nxt;
      end
   end

   // R2: a right guess below the top raises the slot by exactly INC
   assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_hit && (int'(mem[wr_idx]) <= CMAX - INC))
      |=> (int'(mem[$past(wr_idx)]) == int'($past(mem[wr_idx])) + INC));

   // R3: a wrong guess far from the bottom lowers the slot by exactly DEC
   assert_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_hit && (int'(mem[wr_idx]) >= CMIN + DEC))
      |=> (int'(mem[$past(wr_idx)]) == int'($past(mem[wr_idx])) - DEC));

   // R3: a wrong guess near the bottom clamps at the minimum
   assert_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_hit && (int'(mem[wr_idx]) < CMIN + DEC))
      |=> (int'(mem[$past(wr_idx)]) == CMIN));

   // R7: no update strobe leaves the addressed slot as it was
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (mem[$past(wr_idx)] == $past(mem[wr_idx])));

   // R1: the first cycle out of reset reads zero everywhere it looks
   assert_init_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (rd_val == '0 && wr_cur == '0));

endmodule

// File: rtl/branch_conf_est.sv
module branch_conf_est
   import bce_pkg::*;
#(
   parameter int        PC_W    = 32,
   parameter int        IDX_LO  = 2,
   parameter int        IDX_W   = 8,
   parameter int        CNT_W   = 6,
   parameter int        INC     = 1,
   parameter int        DEC     = 9,
   parameter idx_mode_e MODE    = IDX_PLAIN,
   parameter bit        OUT_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] qry_pc,
   output logic            qry_conf,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_hit
);

   logic [IDX_W-1:0]        q_idx;
   logic [IDX_W-1:0]        u_idx;
   logic signed [CNT_W-1:0] q_val;
   logic                    q_above;

   bce_index #(
      .PC_W (PC_W), .IDX_LO (IDX_LO), .IDX_W (IDX_W), .MODE (MODE)
   ) u_qidx (
      .pc  (qry_pc),
      .idx (q_idx)
   );

   bce_index #(
      .PC_W (PC_W), .IDX_LO (IDX_LO), .IDX_W (IDX_W), .MODE (MODE)
   ) u_uidx (
      .pc  (upd_pc),
      .idx (u_idx)
   );

   bce_table #(
      .IDX_W (IDX_W), .CNT_W (CNT_W), .INC (INC), .DEC (DEC)
   ) u_tab (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (q_idx),
      .rd_val (q_val),
      .wr_en  (upd_valid),
      .wr_idx (u_idx),
      .wr_hit (upd_hit)
   );

   assign q_above = (q_val > 0);

   generate
      if (OUT_REG) begin : g_reg_out
         logic conf_q;
         always_ff @(posedge clk) begin
            if (!rst_n) conf_q <= 1'b0;
            else        conf_q <= q_above;
         end
         assign qry_conf = conf_q;
      end else begin : g_comb_out
         assign qry_conf = q_above;
         // R6: a colliding update is not visible until the next cycle
         assert_preupd_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_valid && (u_idx == q_idx) && $stable(qry_pc) && !upd_hit && qry_conf
             && (q_val <= DEC))
            |=> (($stable(qry_pc)) ? !qry_conf : 1'b1));
      end
   endgenerate

endmodule

// File: tb/branch_conf_est_test.sv
module branch_conf_est_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] qry_pc = '0;
   logic        qry_conf;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_hit = 1'b0;

   int n_chk  = 0;
   int n_fail = 0;
   int model [256];
   int cyc = 0;

   always #4 clk = ~clk;

   branch_conf_est uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .qry_pc    (qry_pc),
      .qry_conf  (qry_conf),
      .upd_valid (upd_valid),
      .upd_pc    (upd_pc),
      .upd_hit   (upd_hit)
   );

   // {pc, hit, expected confident afterwards}
   localparam logic [33:0] VEC [12] = '{
      {32'h0000_0200, 1'b1, 1'b1},
      {32'h0000_0200, 1'b1, 1'b1},
      {32'h0000_0200, 1'b0, 1'b0},
      {32'h0000_0200, 1'b1, 1'b0},
      {32'h0000_0200, 1'b1, 1'b0},
      {32'h0000_0200, 1'b1, 1'b0},
      {32'h0000_0200, 1'b1, 1'b0},
      {32'h0000_0200, 1'b1, 1'b0},
      {32'h0000_0200, 1'b1, 1'b0},
      {32'h0000_0200, 1'b1, 1'b0},
      {32'h0000_0200, 1'b1, 1'b1},
      {32'h0000_03FC, 1'b1, 1'b1}
   };

   function automatic int slot(input logic [31:0] pc);
      return int'(pc[9:2]);
   endfunction

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic check(input string req, input logic [31:0] pc, input logic exp);
      qry_pc = pc;
      #1;
      n_chk++;
      if (qry_conf !== exp) begin
         n_fail++;
         $display("FAIL %s pc=%h actual=%b expected=%b", req, pc, qry_conf, exp);
      end
   endtask

   task automatic upd(input logic [31:0] pc, input logic hit);
      @(negedge clk);
      upd_valid = 1'b1;
      upd_pc    = pc;
      upd_hit   = hit;
      @(posedge clk);
      #1;
      upd_valid = 1'b0;
      if (hit) model[slot(pc)] = (model[slot(pc)] + 1 > 31) ? 31 : model[slot(pc)] + 1;
      else     model[slot(pc)] = (model[slot(pc)] - 9 < -32) ? -32 : model[slot(pc)] - 9;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d cycles expected=done", cyc);
            report();
         end
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) model[i] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: nothing confident after reset
      for (int i = 0; i < 8; i++) check("R1", 32'(i * 132), 1'b0);

      // R2 R3 R4: vector walk
      for (int k = 0; k < 12; k++) begin
         upd(VEC[k][33:2], VEC[k][1]);
         check("R4", VEC[k][33:2], VEC[k][0]);
      end

      // R4: 19 right in 20 turns a fresh slot confident
      for (int i = 0; i < 20; i++) upd(32'h040, (i != 19));
      check("R4", 32'h040, 1'b1);

      // R3: one miss near zero pulls it back
      for (int i = 0; i < 5; i++) upd(32'h044, 1'b1);
      check("R2", 32'h044, 1'b1);
      upd(32'h044, 1'b0);
      check("R3", 32'h044, 1'b0);

      // R2: top clamp at 31 (no wrap, no overshoot)
      for (int i = 0; i < 40; i++) upd(32'h080, 1'b1);
      check("R2", 32'h080, 1'b1);
      for (int i = 0; i < 3; i++) upd(32'h080, 1'b0);
      check("R2", 32'h080, 1'b1);
      upd(32'h080, 1'b0);
      check("R2", 32'h080, 1'b0);

      // R3: bottom clamp at -32
      for (int i = 0; i < 10; i++) upd(32'h084, 1'b0);
      for (int i = 0; i < 32; i++) upd(32'h084, 1'b1);
      check("R3", 32'h084, 1'b0);
      upd(32'h084, 1'b1);
      check("R3", 32'h084, 1'b1);

      // R5: aliasing through bits [1:0] and above bit 9
      upd(32'h100, 1'b1);
      check("R5", 32'h0000_1100, 1'b1);
      check("R5", 32'hFFFF_FD03, 1'b1);
      // R8: neighbour slot untouched
      check("R8", 32'h104, 1'b0);

      // R7: strobe low, other fields wiggling
      @(negedge clk);
      upd_valid = 1'b0; upd_pc = 32'h180; upd_hit = 1'b1;
      repeat (4) @(posedge clk);
      #1 check("R7", 32'h180, 1'b0);
      @(negedge clk);
      upd_pc = 32'h100; upd_hit = 1'b0;
      repeat (4) @(posedge clk);
      #1 check("R7", 32'h100, 1'b1);

      // R6: collision returns the value from before the write
      upd(32'h140, 1'b1);
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = 32'h140; upd_hit = 1'b0;
      check("R6", 32'h140, 1'b1);
      @(posedge clk);
      #1 upd_valid = 1'b0;
      model[slot(32'h140)] = -8;
      check("R6", 32'h140, 1'b0);

      // R4: model sweep over all touched slots
      for (int i = 0; i < 256; i++) check("R4", 32'(i * 4), model[i] > 0);

      report();
   end

endmodule